// File: doc/BRIEF.md
# Boundary-Scan Test Port Controller

This block is the test access port of a chip. It runs entirely on its own test clock and is steered by a serial mode line. A sixteen-state controller decides what the port does at each rising test-clock edge. It can load a 4-bit instruction, or it can capture, shift and update one of three data registers: a one-bit bypass stage, a 32-bit identification word, or a boundary chain of configurable length that sits between the core and the pins. Serial data enters on the rising edge. The serial output and its drive enable change on the falling edge, so that a board-level scan chain has half a clock of margin in both directions.

There is no dedicated asynchronous test reset. A power-on reset, held for at least one rising test-clock edge, returns the controller to its reset state. Five consecutive rising edges with the mode line high do the same. A separate lock input disables the whole port. While the lock is high, the controller is held in its reset state and the serial output is not driven. The boundary chain presents a parallel capture input toward the pins and a parallel holding output. The holding output changes only when the controller passes through the data-update state.

Top module: `scan_port_ctrl`

## Requirements
- R1: After power-on reset the serial output enable is low, the boundary holding outputs are all zero, and the instruction in force is the identification instruction (code 0010).
- R2: `tdo_oe` is high only while the controller is in the instruction-shift or data-shift state, and is low in every other state.
- R3: Shifting the instruction register returns the fixed pattern 0001, least significant bit first, captured in the instruction-capture state.
- R4: With the identification instruction in force, a data scan returns the 32-bit identification constant, least significant bit first; that bit is 1.
- R5: Code 1111 selects the bypass stage, and so does every code other than 0000, 0010 and 0011. The bypass stage captures 0 and delays TDI to TDO by exactly one shift.
- R6: Codes 0000 and 0011 select the boundary chain. A data scan returns the parallel capture input sampled in the data-capture state, bit 0 first.
- R7: The boundary holding outputs stay unchanged during capture and shifting. They take the shifted-in chain contents (the last TDI bit landing in the top bit) on the rising edge that leaves the data-update state.
- R8: Five consecutive rising edges with TMS high bring the controller to its reset state from any state, which puts the identification instruction back in force.
- R9: While `test_lock` is high, the controller is held in its reset state whatever TMS does and TDO is not enabled. After release, the identification instruction is in force.
- R10: TDO and `tdo_oe` change only on falling test-clock edges; a value present before a rising edge is still present just after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| por | input | 1 | Power-on reset, active high, sampled on the test clock |
| test_lock | input | 1 | High disables the port and holds the controller in reset |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_oe | output | 1 | Drive enable for the TDO pad |
| bnd_capture | input | BLEN | Parallel values captured into the boundary chain |
| bnd_update | output | BLEN | Boundary holding register toward the pins |

## Verification
Each shifted bit appears on TDO at the falling edge that follows the rising edge that entered, or stayed in, a shift state. The bench therefore compares TDO and its enable 2 time units after every falling edge, against an expectation queued for that edge. The boundary holding outputs change one rising edge after the controller enters the data-update state, so they are compared only after one further idle clock. They are compared against their old value after every shift. The stability of TDO across a rising edge is checked 1 time unit after that edge, before the next falling edge.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;

    localparam int IR_W = 4;
    localparam int ID_W = 32;

    typedef logic [IR_W-1:0] opcode_t;

    localparam opcode_t OP_DRIVE       = 4'b0000;
    localparam opcode_t OP_IDENT       = 4'b0010;
    localparam opcode_t OP_SAMPLE      = 4'b0011;
    localparam opcode_t OP_BYPASS      = 4'b1111;
    localparam opcode_t IR_CAPTURE_PAT = 4'b0001;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        SEL_BYPASS,
        SEL_IDENT,
        SEL_BOUND
    } dr_sel_e;

    typedef struct packed {
        logic capture;
        logic shift;
        logic update;
    } dr_ctl_t;

    function automatic tap_state_e tap_next(tap_state_e s, logic tms);
        case (s)
            ST_TLR:    return tms ? ST_TLR    : ST_RTI;
            ST_RTI:    return tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: return tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: return tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  return tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: return tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: return tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: return tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: return tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: return tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: return tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  return tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: return tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: return tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: return tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: return tms ? ST_SEL_DR : ST_RTI;
            default:   return ST_TLR;
        endcase
    endfunction

    function automatic dr_sel_e op_decode(opcode_t op);
        case (op)
            OP_IDENT:            return SEL_IDENT;
            OP_DRIVE, OP_SAMPLE: return SEL_BOUND;
            default:             return SEL_BYPASS;
        endcase
    endfunction

    function automatic dr_ctl_t dr_ctl(tap_state_e s, dr_sel_e sel, dr_sel_e mine);
        dr_ctl_t c;
        c.capture = (s == ST_CAP_DR) && (sel == mine);
        c.shift   = (s == ST_SH_DR)  && (sel == mine);
        c.update  = (s == ST_UPD_DR) && (sel == mine);
        return c;
    endfunction

endpackage

// File: rtl/scan_fsm.sv
module scan_fsm
    import scan_port_pkg::*;
(
    input  logic       tck,
    input  logic       por,
    input  logic       test_lock,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e state_q;

    always_ff @(posedge tck) begin
        if (por || test_lock) begin
            state_q <= ST_TLR;
        end else begin
            state_q <= tap_next(state_q, tms);
        end
    end

    assign state = state_q;

    // Checker: consecutive rising edges with TMS high, saturating at five.
    logic [2:0] ones_q;
    always_ff @(posedge tck) begin
        if (por || !tms) begin
            ones_q <= 3'd0;
        end else if (ones_q != 3'd5) begin
            ones_q <= ones_q + 3'd1;
        end
    end

    assert_five_ones_reset_R8: assert property (@(posedge tck) disable iff (por)
        (ones_q == 3'd5) |-> (state_q == ST_TLR));

    assert_lock_holds_reset_R9: assert property (@(posedge tck) disable iff (por)
        test_lock |=> (state_q == ST_TLR));

endmodule

// File: rtl/scan_ir.sv
module scan_ir
    import scan_port_pkg::*;
(
    input  logic       tck,
    input  logic       por,
    input  tap_state_e state,
    input  logic       tdi,
    output opcode_t    opcode,
    output logic       ir_lsb
);

    opcode_t ir_q;
    opcode_t sh_q;

    always_ff @(posedge tck) begin
        if (por || state == ST_TLR) begin
            ir_q <= OP_IDENT;
            sh_q <= IR_CAPTURE_PAT;
        end else begin
            case (state)
                ST_CAP_IR: sh_q <= IR_CAPTURE_PAT;
                ST_SH_IR:  sh_q <= {tdi, sh_q[IR_W-1:1]};
                ST_UPD_IR: ir_q <= sh_q;
                default:   ;
            endcase
        end
    end

    assign opcode = ir_q;
    assign ir_lsb = sh_q[0];

    assert_capture_pattern_R3: assert property (@(posedge tck) disable iff (por)
        (state == ST_CAP_IR) |=> (sh_q == IR_CAPTURE_PAT));

    assert_ident_on_reset_R1: assert property (@(posedge tck) disable iff (por)
        (state == ST_TLR) |=> (ir_q == OP_IDENT));

    assert_ir_only_in_update_R3: assert property (@(posedge tck) disable iff (por)
        (state != ST_UPD_IR && state != ST_TLR) |=> $stable(ir_q));

endmodule

// File: rtl/scan_bchain.sv
module scan_bchain #(
    parameter int BLEN = 265
) (
    input  logic            tck,
    input  logic            por,
    input  logic            capture_en,
    input  logic            shift_en,
    input  logic            update_en,
    input  logic            tdi,
    input  logic [BLEN-1:0] par_in,
    output logic [BLEN-1:0] par_out,
    output logic            lsb
);

    logic [BLEN-1:0] chain;
    logic [BLEN-1:0] shin;

    for (genvar i = 0; i < BLEN; i++) begin : g_cell
        if (i == BLEN - 1) begin : g_top
            assign shin[i] = tdi;
        end else begin : g_mid
            assign shin[i] = chain[i+1];
        end

        logic cap_q;
        logic hold_q;

        always_ff @(posedge tck) begin
            if (por) begin
                cap_q <= 1'b0;
            end else if (capture_en) begin
                cap_q <= par_in[i];
            end else if (shift_en) begin
                cap_q <= shin[i];
            end
        end

        always_ff @(posedge tck) begin
            if (por) begin
                hold_q <= 1'b0;
            end else if (update_en) begin
                hold_q <= cap_q;
            end
        end

        assign chain[i]   = cap_q;
        assign par_out[i] = hold_q;
    end

    assign lsb = chain[0];

    assert_hold_stable_R7: assert property (@(posedge tck) disable iff (por)
        !update_en |=> $stable(par_out));

endmodule

// File: rtl/scan_dr.sv
module scan_dr
    import scan_port_pkg::*;
#(
    parameter int              BLEN     = 265,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h0B7A_C01D
) (
    input  logic            tck,
    input  logic            por,
    input  tap_state_e      state,
    input  opcode_t         opcode,
    input  logic            tdi,
    input  logic [BLEN-1:0] bnd_capture,
    output logic [BLEN-1:0] bnd_update,
    output logic            dr_lsb
);

    dr_sel_e   sel;
    dr_ctl_t   byp_ctl, id_ctl, bnd_ctl;
    logic      byp_q;
    logic [ID_W-1:0] id_q;
    logic      bnd_lsb;

    assign sel     = op_decode(opcode);
    assign byp_ctl = dr_ctl(state, sel, SEL_BYPASS);
    assign id_ctl  = dr_ctl(state, sel, SEL_IDENT);
    assign bnd_ctl = dr_ctl(state, sel, SEL_BOUND);

    always_ff @(posedge tck) begin
        if (por) begin
            byp_q <= 1'b0;
        end else if (byp_ctl.capture) begin
            byp_q <= 1'b0;
        end else if (byp_ctl.shift) begin
            byp_q <= tdi;
        end
    end

    always_ff @(posedge tck) begin
        if (por) begin
            id_q <= '0;
        end else if (id_ctl.capture) begin
            id_q <= ID_VALUE;
        end else if (id_ctl.shift) begin
            id_q <= {tdi, id_q[ID_W-1:1]};
        end
    end

    scan_bchain #(.BLEN(BLEN)) bchain_i (
        .tck        (tck),
        .por        (por),
        .capture_en (bnd_ctl.capture),
        .shift_en   (bnd_ctl.shift),
        .update_en  (bnd_ctl.update),
        .tdi        (tdi),
        .par_in     (bnd_capture),
        .par_out    (bnd_update),
        .lsb        (bnd_lsb)
    );

    always_comb begin
        case (sel)
            SEL_IDENT: dr_lsb = id_q[0];
            SEL_BOUND: dr_lsb = bnd_lsb;
            default:   dr_lsb = byp_q;
        endcase
    end

    assert_bypass_captures_zero_R5: assert property (@(posedge tck) disable iff (por)
        byp_ctl.capture |=> (byp_q == 1'b0));

endmodule

// File: rtl/scan_port_ctrl.sv
module scan_port_ctrl
    import scan_port_pkg::*;
#(
    parameter int              BLEN     = 265,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h0B7A_C01D
) (
    input  logic            tck,
    input  logic            por,
    input  logic            test_lock,
    input  logic            tms,
    input  logic            tdi,
    output logic            tdo,
    output logic            tdo_oe,
    input  logic [BLEN-1:0] bnd_capture,
    output logic [BLEN-1:0] bnd_update
);

    tap_state_e state;
    opcode_t    opcode;
    logic       ir_lsb;
    logic       dr_lsb;
    logic       tdo_q, oe_q;

    scan_fsm fsm_i (
        .tck       (tck),
        .por       (por),
        .test_lock (test_lock),
        .tms       (tms),
        .state     (state)
    );

    scan_ir ir_i (
        .tck    (tck),
        .por    (por),
        .state  (state),
        .tdi    (tdi),
        .opcode (opcode),
        .ir_lsb (ir_lsb)
    );

    scan_dr #(.BLEN(BLEN), .ID_VALUE(ID_VALUE)) dr_i (
        .tck         (tck),
        .por         (por),
        .state       (state),
        .opcode      (opcode),
        .tdi         (tdi),
        .bnd_capture (bnd_capture),
        .bnd_update  (bnd_update),
        .dr_lsb      (dr_lsb)
    );

    // Output stage on the falling edge: half a clock after the state moved.
    always_ff @(negedge tck) begin
        if (por || test_lock) begin
            tdo_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            oe_q  <= (state == ST_SH_IR) || (state == ST_SH_DR);
            tdo_q <= (state == ST_SH_IR) ? ir_lsb : dr_lsb;
        end
    end

    assign tdo    = tdo_q;
    assign tdo_oe = oe_q;

    assert_oe_only_in_shift_R2: assert property (@(posedge tck) disable iff (por)
        tdo_oe |-> (state == ST_SH_IR || state == ST_SH_DR));

endmodule

// File: tb/scan_port_ctrl_tb_top.sv
module scan_port_ctrl_tb_top;

    localparam int          PERIOD = 10;
    localparam int          BLEN   = 265;
    localparam logic [31:0] ID_EXP = 32'h0B7A_C01D;

    logic            tck = 1'b0;
    logic            por, test_lock, tms, tdi;
    logic            tdo, tdo_oe;
    logic [BLEN-1:0] bnd_capture, bnd_update;

    int checks = 0;
    int fails  = 0;

    always #(PERIOD/2) tck = ~tck;

    scan_port_ctrl #(.BLEN(BLEN), .ID_VALUE(ID_EXP)) dut_i (
        .tck         (tck),
        .por         (por),
        .test_lock   (test_lock),
        .tms         (tms),
        .tdi         (tdi),
        .tdo         (tdo),
        .tdo_oe      (tdo_oe),
        .bnd_capture (bnd_capture),
        .bnd_update  (bnd_update)
    );

    typedef struct {
        logic  oe;
        logic  val;
        bit    chk;
        string tag;
    } exp_t;

    exp_t sb_q[$];

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Monitor: one expectation per falling edge while the queue holds items.
    initial begin
        forever begin
            @(negedge tck);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                logic seen;
                e = sb_q.pop_front();
                check(tdo_oe === e.oe, "R2", {63'd0, tdo_oe}, {63'd0, e.oe});
                if (e.chk) begin
                    check(tdo === e.val, e.tag, {63'd0, tdo}, {63'd0, e.val});
                    seen = tdo;
                    @(posedge tck);
                    #1;
                    check(tdo === seen, "R10", {63'd0, tdo}, {63'd0, seen});
                end
            end
        end
    end

    // Driver: queue what the next falling edge must show, then drive inputs.
    task automatic step(logic t, logic d, logic eoe, logic ev, bit chk, string tag);
        exp_t e;
        e.oe = eoe; e.val = ev; e.chk = chk; e.tag = tag;
        sb_q.push_back(e);
        @(negedge tck);
        #3;
        tms = t;
        tdi = d;
    endtask

    task automatic ir_scan(logic [3:0] op, string tag);
        step(1, 0, 0, 0, 0, tag);   // RTI
        step(1, 0, 0, 0, 0, tag);   // select DR
        step(0, 0, 0, 0, 0, tag);   // select IR
        step(0, 0, 0, 0, 0, tag);   // capture IR
        for (int i = 0; i < 4; i++)
            step(i == 3, op[i], 1, (i == 0), 1, tag);   // captured 0001
        step(1, 0, 0, 0, 0, tag);   // exit1
        step(0, 0, 0, 0, 0, tag);   // update
    endtask

    task automatic dr_scan(int n, logic [511:0] din, logic [511:0] ex, string tag,
                           bit watch_hold);
        logic [BLEN-1:0] hold0;
        hold0 = bnd_update;
        step(1, 0, 0, 0, 0, tag);   // RTI
        step(0, 0, 0, 0, 0, tag);   // select DR
        step(0, 0, 0, 0, 0, tag);   // capture DR
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], 1, ex[i], 1, tag);
            if (watch_hold) check(bnd_update === hold0, "R7", 64'(bnd_update), 64'(hold0));
        end
        step(1, 0, 0, 0, 0, tag);   // exit1
        step(0, 0, 0, 0, 0, tag);   // update
    endtask

    task automatic drain();
        while (sb_q.size() > 0) @(negedge tck);
        @(negedge tck);
        #3;
    endtask

    initial begin
        #(PERIOD * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [BLEN-1:0] cap_pat, shin_pat;
        logic [511:0]    bx;
        por = 1; test_lock = 0; tms = 1; tdi = 0;
        bnd_capture = '0;
        repeat (3) @(posedge tck);
        @(negedge tck);
        #3;
        por = 0;

        // R1: reset state at the ports.
        check(tdo_oe === 1'b0, "R1", {63'd0, tdo_oe}, 64'd0);
        check(bnd_update === '0, "R1", 64'(bnd_update), 64'd0);

        // R1/R4: identification word in force after reset.
        step(0, 0, 0, 0, 0, "R1");                       // TLR -> RTI
        dr_scan(32, 512'hA5A5_3C3C, {480'd0, ID_EXP}, "R4", 0);
        dr_scan(32, 512'h0, {480'd0, ID_EXP}, "R4", 0);

        // R3 + R5: load bypass, then delay by one.
        ir_scan(4'b1111, "R3");
        dr_scan(8, 512'b1011_0010, 512'b0110_0100, "R5", 0);

        // R5: an unassigned code also selects bypass.
        ir_scan(4'b0110, "R3");
        dr_scan(6, 512'b11_0101, 512'b10_1010, "R5", 0);

        // R6/R7: sample/preload then drive code on the boundary chain.
        for (int i = 0; i < BLEN; i++) begin
            cap_pat[i]  = ((i % 3) == 0) ^ ((i / 16) % 2 == 1);
            shin_pat[i] = ((i % 5) == 1) || ((i % 7) == 0);
        end
        bnd_capture = cap_pat;
        ir_scan(4'b0011, "R3");
        bx = '0; bx[BLEN-1:0] = cap_pat;
        dr_scan(BLEN, {247'd0, shin_pat}, bx, "R6", 1);
        step(0, 0, 0, 0, 0, "R7");                       // idle in RTI
        drain();
        check(bnd_update === shin_pat, "R7", 64'(bnd_update), 64'(shin_pat));

        bnd_capture = ~cap_pat;
        ir_scan(4'b0000, "R3");
        bx = '0; bx[BLEN-1:0] = ~cap_pat;
        dr_scan(BLEN, {247'd0, ~shin_pat}, bx, "R6", 1);
        step(0, 0, 0, 0, 0, "R7");
        drain();
        check(bnd_update === ~shin_pat, "R7", 64'(bnd_update), 64'(~shin_pat));

        // R8: five TMS-high edges from the middle of a data shift.
        ir_scan(4'b1111, "R3");
        step(1, 0, 0, 0, 0, "R8");                       // RTI
        step(0, 0, 0, 0, 0, "R8");                       // select DR
        step(0, 0, 0, 0, 0, "R8");                       // capture DR
        step(0, 1, 1, 0, 1, "R8");                       // shift, captured 0
        step(1, 0, 1, 1, 1, "R8");                       // shift, delayed 1
        step(1, 0, 0, 0, 0, "R8");                       // exit1
        step(1, 0, 0, 0, 0, "R8");                       // update
        step(1, 0, 0, 0, 0, "R8");                       // select DR
        step(1, 0, 0, 0, 0, "R8");                       // select IR
        step(0, 0, 0, 0, 0, "R8");                       // TLR -> RTI
        dr_scan(32, 512'h0, {480'd0, ID_EXP}, "R8", 0);

        // R9: lock while shifting; controller pinned in reset.
        ir_scan(4'b1111, "R3");
        step(1, 0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 0, "R9");
        step(0, 1, 1, 0, 1, "R9");                       // in shift DR
        test_lock = 1;
        step(0, 0, 0, 0, 0, "R9");
        step(1, 0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 0, "R9");
        drain();
        check(tdo_oe === 1'b0, "R9", {63'd0, tdo_oe}, 64'd0);
        test_lock = 0;
        step(0, 0, 0, 0, 0, "R9");                       // TLR -> RTI
        dr_scan(32, 512'hFFFF_FFFF, {480'd0, ID_EXP}, "R9", 0);

        drain();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule